// File: doc/BRIEF.md
# Line-State Synchronized Descrambler

This block recovers plaintext from a stream that an additive scrambler has masked, five bits at a time. It has its own 11-stage pseudo-random generator with feedback x^11 + x^9 + 1. For every accepted group the generator advances five steps, and the new key bits are XORed with the received group. The generator runs open loop, so the received data never steers it. On its own it can only stay in step with the far end. It cannot get into step.

To get into step, the block keeps a 22-bit history of received bits. From that history it forms a signature that cancels the key stream, and it compares the signature with those of the known line-state fills: Idle, Halt, Master and Quiet. A match means the plaintext window is known. The key window is then the newest 11 received bits XOR that known plaintext, and the generator is loaded with this value. A load takes place only while the surrounding receiver raises the capture-permit input. After one correct load the two generators stay aligned indefinitely.

Top module: `lsDescrambler`

## Requirements
- R1: While `rst` is high at a clock edge, `dataOut`, `outValid` and `capture` clear to zero and the generator is seeded with all ones. As a result, the first group received after reset is descrambled with the sequence that continues from the all-ones state.
- R2: One clock after a group is accepted (`inValid` high), `outValid` is 1 and `dataOut` equals `rxScr` XOR the next five key bits, with bit 4 the earliest bit in time. `outValid` is 0 one clock after a cycle with `inValid` low.
- R3: A cycle with `inValid` low neither advances nor loads the generator, so the key sequence resumes unchanged at the next accepted group.
- R4: Key bits obey s[n] = s[n-9] XOR s[n-11]. Each accepted group that is not a load advances the generator exactly five bits.
- R5: With bit age counted so that c[n] is the newest received bit, the signature bit i (i = 0..10) is c[n-i] XOR c[n-i-9] XOR c[n-i-11]. It is compared with the signatures of five 22-bit plaintext windows, in this priority: all ones (Idle); repeated group 00100 (Halt); Halt and zero groups alternating, with Halt newest (Master phase A); the same with zero newest (Master phase B); all zeros (Quiet). A valid match loads the generator, and `capture` pulses one clock after that group.
- R6: While `permit` is low, no load occurs and `capture` stays 0, whatever the received data.
- R7: A load sets the generator to the newest 11 received bits XOR the matched plaintext window. The output group of that cycle equals the plaintext group, and from then on `dataOut` reproduces the scrambler's input.
- R8: A deduced all-zero generator state is rejected. No load and no `capture` follow, and the generator never holds zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | A scrambled group is present on `rxScr` |
| rxScr | input | 5 | Received scrambled group, bit 4 earliest |
| permit | input | 1 | Capture permitted while high |
| dataOut | output | 5 | Descrambled group, bit 4 earliest |
| outValid | output | 1 | `dataOut` holds a new group |
| capture | output | 1 | The generator was loaded from a line-state match for this group |

## Verification
Every result of this block falls due exactly one clock after its input group: the descrambled group, its valid flag and the capture pulse are all registered once, and the detection logic is combinational from the incoming group. The bench drives a group at the falling edge and samples 1 ns after the next rising edge. A behavioural model that tracks bits one at a time predicts the same cycle. Synchronization is judged by comparing `dataOut` directly with the plaintext that was fed to the bench's own scrambler in the same group.

// File: rtl/lsdPkg.sv
`timescale 1ns/1ps
package lsdPkg;
  localparam int GEN_LEN = 11;
  localparam int GEN_TAP = 9;
  localparam int GRP     = 5;
  localparam int HIST    = 2 * GEN_LEN;
  localparam int NUM_PAT = 5;

  localparam logic [GRP-1:0] HALT_GRP = 5'b00100;

  typedef logic [GEN_LEN-1:0] genState_t;

  typedef struct packed {
    logic      advance;
    logic      load;
    genState_t seed;
  } ctlStrobe_t;

  // Advance the generator GRP steps. Bit i of the state is the key bit of age i.
  function automatic genState_t stepGen(genState_t st);
    logic [GEN_LEN+GRP-1:0] w;
    w = '0;
    w[GEN_LEN+GRP-1:GRP] = st;
    for (int j = GRP - 1; j >= 0; j--) begin
      w[j] = w[j+GEN_TAP] ^ w[j+GEN_LEN];
    end
    return w[GEN_LEN-1:0];
  endfunction

  // Key-cancelling signature over a HIST-bit window (bit 0 newest).
  function automatic genState_t signature(logic [HIST-1:0] w);
    genState_t s;
    for (int i = 0; i < GEN_LEN; i++) begin
      s[i] = w[i] ^ w[i+GEN_TAP] ^ w[i+GEN_LEN];
    end
    return s;
  endfunction

  // Plaintext window of a line state. kind: 0 idle, 1 halt, 2 master A, 3 master B, 4 quiet.
  function automatic logic [HIST-1:0] patWindow(int kind);
    logic [HIST-1:0] w;
    for (int i = 0; i < HIST; i++) begin
      int grpIdx;
      int bitIdx;
      grpIdx = i / GRP;
      bitIdx = i % GRP;
      case (kind)
        0:       w[i] = 1'b1;
        1:       w[i] = HALT_GRP[bitIdx];
        2:       w[i] = (grpIdx % 2 == 0) ? HALT_GRP[bitIdx] : 1'b0;
        3:       w[i] = (grpIdx % 2 == 1) ? HALT_GRP[bitIdx] : 1'b0;
        default: w[i] = 1'b0;
      endcase
    end
    return w;
  endfunction
endpackage

// File: rtl/lsdSyncCtrl.sv
`timescale 1ns/1ps
module lsdSyncCtrl
  import lsdPkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                inValid,
  input  logic                permit,
  input  logic [GRP-1:0]      rxGroup,
  output ctlStrobe_t          ctl
);
  localparam int KEEP = HIST - GRP;

  logic [KEEP-1:0]    rxHist;
  logic [HIST-1:0]    histNext;
  genState_t          sigObs;
  logic [NUM_PAT-1:0] hitOk;
  genState_t          cand [NUM_PAT];
  genState_t          chosen;
  logic               anyOk;

  assign histNext = {rxHist, rxGroup};
  assign sigObs   = signature(histNext);

  generate
    for (genvar k = 0; k < NUM_PAT; k++) begin : g_pat
      localparam logic [HIST-1:0] PWIN = patWindow(k);
      localparam genState_t       PSIG = signature(PWIN);
      assign cand[k]  = histNext[GEN_LEN-1:0] ^ PWIN[GEN_LEN-1:0];
      assign hitOk[k] = (sigObs == PSIG) && (|cand[k]);
    end
  endgenerate

  // Lowest index wins.
  always_comb begin
    chosen = '0;
    anyOk  = 1'b0;
    for (int k = NUM_PAT - 1; k >= 0; k--) begin
      if (hitOk[k]) begin
        chosen = cand[k];
        anyOk  = 1'b1;
      end
    end
  end

  assign ctl.advance = inValid;
  assign ctl.load    = inValid && permit && anyOk;
  assign ctl.seed    = chosen;

  always_ff @(posedge clk) begin
    if (rst) rxHist <= '0;
    else if (inValid) rxHist <= histNext[KEEP-1:0];
  end
endmodule

// File: rtl/lsdKeyGen.sv
`timescale 1ns/1ps
module lsdKeyGen
  import lsdPkg::*;
#(
  parameter genState_t SEED = '1
) (
  input  logic           clk,
  input  logic           rst,
  input  ctlStrobe_t     ctl,
  input  logic [GRP-1:0] rxGroup,
  output logic [GRP-1:0] dataOut,
  output logic           outValid,
  output logic           capture,
  output genState_t      genState
);
  genState_t genNext;
  genState_t keyState;

  assign genNext  = stepGen(genState);
  assign keyState = ctl.load ? ctl.seed : genNext;

  always_ff @(posedge clk) begin
    if (rst) begin
      genState <= SEED;
      dataOut  <= '0;
      outValid <= 1'b0;
      capture  <= 1'b0;
    end else begin
      outValid <= ctl.advance;
      capture  <= ctl.load;
      if (ctl.advance) begin
        genState <= keyState;
        dataOut  <= rxGroup ^ keyState[GRP-1:0];
      end
    end
  end
endmodule

// File: rtl/lsDescrambler.sv
`timescale 1ns/1ps
module lsDescrambler
  import lsdPkg::*;
#(
  parameter genState_t SEED = '1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           inValid,
  input  logic [GRP-1:0] rxScr,
  input  logic           permit,
  output logic [GRP-1:0] dataOut,
  output logic           outValid,
  output logic           capture
);
  ctlStrobe_t ctl;
  genState_t  genState;
  logic       loadStrobe;

  assign loadStrobe = ctl.load;

  lsdSyncCtrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .permit  (permit),
    .rxGroup (rxScr),
    .ctl     (ctl)
  );

  lsdKeyGen #(.SEED(SEED)) u_gen (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .rxGroup  (rxScr),
    .dataOut  (dataOut),
    .outValid (outValid),
    .capture  (capture),
    .genState (genState)
  );
endmodule

// File: rtl/lsDescramblerChk.sv
`timescale 1ns/1ps
module lsDescramblerChk
  import lsdPkg::*;
(
  input logic      clk,
  input logic      rst,
  input logic      inValid,
  input logic      permit,
  input logic      outValid,
  input logic      capture,
  input logic      loadStrobe,
  input genState_t genState
);
  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else armed <= 1'b1;
  end

  p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
    armed |-> (outValid == $past(inValid)));

  p_hold_idle_r3: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(inValid)) |-> $stable(genState));

  p_shift_r4: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(inValid) && !$past(loadStrobe))
      |-> (genState[GEN_LEN-1:GRP] == $past(genState[GEN_LEN-GRP-1:0])));

  p_capture_gate_r6: assert property (@(posedge clk) disable iff (rst)
    (armed && capture) |-> ($past(permit) && $past(inValid)));

  p_capture_valid_r7: assert property (@(posedge clk) disable iff (rst)
    capture |-> outValid);

  p_nonzero_r8: assert property (@(posedge clk) disable iff (rst)
    armed |-> (genState != '0));
endmodule

bind lsDescrambler lsDescramblerChk u_chk (
  .clk        (clk),
  .rst        (rst),
  .inValid    (inValid),
  .permit     (permit),
  .outValid   (outValid),
  .capture    (capture),
  .loadStrobe (loadStrobe),
  .genState   (genState)
);

// File: tb/test_lsDescrambler.sv
`timescale 1ns/1ps
module test_lsDescrambler;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       inValid = 1'b0;
  logic [4:0] rxScr = '0;
  logic       permit = 1'b0;
  logic [4:0] dataOut;
  logic       outValid;
  logic       capture;

  lsDescrambler i_lsDescrambler (
    .clk(clk), .rst(rst), .inValid(inValid), .rxScr(rxScr), .permit(permit),
    .dataOut(dataOut), .outValid(outValid), .capture(capture)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  int scrG[11];
  int mG[11];
  int rxH[22];
  logic [4:0] expData;
  logic expValid, expCap;
  string curTag = "R2";
  int capSeen;
  int unsigned lcg = 32'h1234_5678;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int scrBit();
    int nb = scrG[8] ^ scrG[10];
    for (int i = 10; i > 0; i--) scrG[i] = scrG[i-1];
    scrG[0] = nb;
    return nb;
  endfunction

  function automatic int modelBit();
    int nb = mG[8] ^ mG[10];
    for (int i = 10; i > 0; i--) mG[i] = mG[i-1];
    mG[0] = nb;
    return nb;
  endfunction

  // kind: 0 idle, 1 halt, 2 master A, 3 master B, 4 quiet; i is bit age
  function automatic int dataBit(int kind, int i);
    int g = i / 5;
    int b = i % 5;
    case (kind)
      0: return 1;
      1: return (b == 2) ? 1 : 0;
      2: return (g % 2 == 0 && b == 2) ? 1 : 0;
      3: return (g % 2 == 1 && b == 2) ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  function automatic logic [4:0] nextRand();
    lcg = lcg * 1103515245 + 12345;
    return lcg[20:16];
  endfunction

  task automatic modelGroup(logic v, logic p, logic [4:0] c);
    int loadKind;
    if (!v) begin
      expValid = 0;
      expCap = 0;
      return;
    end
    for (int i = 21; i >= 5; i--) rxH[i] = rxH[i-5];
    for (int b = 0; b < 5; b++) rxH[b] = c[b];
    loadKind = -1;
    for (int k = 0; k < 5 && loadKind < 0; k++) begin
      bit match = 1;
      bit nz = 0;
      for (int i = 0; i < 11; i++) begin
        int so = rxH[i] ^ rxH[i+9] ^ rxH[i+11];
        int sp = dataBit(k, i) ^ dataBit(k, i+9) ^ dataBit(k, i+11);
        if (so != sp) match = 0;
        if ((rxH[i] ^ dataBit(k, i)) != 0) nz = 1;
      end
      if (match && nz) loadKind = k;
    end
    if (p && loadKind >= 0) begin
      for (int i = 0; i < 11; i++) mG[i] = rxH[i] ^ dataBit(loadKind, i);
      for (int b = 0; b < 5; b++) expData[b] = c[b] ^ mG[b][0];
      expCap = 1;
    end else begin
      for (int t = 0; t < 5; t++) expData[4-t] = c[4-t] ^ modelBit();
      expCap = 0;
    end
    expValid = 1;
  endtask

  task automatic step(logic v, logic p, logic [4:0] c);
    @(negedge clk);
    inValid = v;
    permit = p;
    rxScr = c;
    modelGroup(v, p, c);
    @(posedge clk);
    #1;
    chk("R2 outValid", outValid, expValid);
    chk("R5 capture", capture, expCap);
    if (expValid) chk({curTag, " dataOut"}, dataOut, expData);
    if (capture) capSeen++;
  endtask

  task automatic sendGroup(logic p, logic [4:0] plain, bit checkPlain);
    logic [4:0] c;
    for (int b = 4; b >= 0; b--) c[b] = plain[b] ^ scrBit();
    step(1, p, c);
    if (checkPlain) chk("R7 plaintext", dataOut, plain);
  endtask

  task automatic resetDut();
    @(negedge clk);
    rst = 1;
    inValid = 0;
    permit = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    for (int i = 0; i < 11; i++) mG[i] = 1;
    for (int i = 0; i < 22; i++) rxH[i] = 0;
    expValid = 0;
    expCap = 0;
    chk("R1 dataOut", dataOut, 0);
    chk("R1 outValid", outValid, 0);
    chk("R1 capture", capture, 0);
  endtask

  task automatic syncThenData(int kind, int n);
    capSeen = 0;
    curTag = "R5";
    for (int g = 0; g < n; g++) begin
      logic [4:0] pl;
      for (int b = 0; b < 5; b++) pl[b] = dataBit(kind, b + 5 * (g % 2 == 0 ? 0 : 1))[0];
      if (kind == 2) pl = (g % 2 == 0) ? 5'b00100 : 5'b00000;
      sendGroup(1, pl, 0);
    end
    chk("R5 captures seen", capSeen > 0, 1);
    curTag = "R7";
    for (int g = 0; g < 16; g++) sendGroup(0, nextRand(), 1);
  endtask

  initial begin
    for (int i = 0; i < 11; i++) scrG[i] = (11'h5A3 >> i) & 1;
    resetDut();

    curTag = "R4";
    step(1, 0, 5'b00000);
    chk("R1 first key group", dataOut, 5'b00000 ^ expData);
    repeat (6) step(1, 0, 5'b00000);

    curTag = "R3";
    for (int k = 0; k < 12; k++) step((k % 3) != 0, 0, 5'(k * 7 + 3));

    curTag = "R6";
    capSeen = 0;
    for (int g = 0; g < 12; g++) sendGroup(0, 5'b11111, 0);
    chk("R6 no capture without permit", capSeen, 0);

    syncThenData(0, 8);
    resetDut();
    syncThenData(1, 8);
    resetDut();
    syncThenData(2, 10);
    resetDut();
    syncThenData(4, 8);

    resetDut();
    curTag = "R8";
    capSeen = 0;
    for (int g = 0; g < 8; g++) step(1, 1, 5'b00000);
    chk("R8 zero state rejected", capSeen, 0);

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule